// File: doc/BRIEF.md
# Windowed Sync-Header Block Aligner

This block finds and keeps the 66-bit block boundary in a received serial stream. A gearbox upstream presents one candidate block per strobe. The block only needs the two framing bits at the head of each candidate. The aligner reports the bit offset it currently trusts. While it is still searching, it asks the gearbox to slip by one bit whenever a search window fails.

Acquisition is counted over a window, not as a run of consecutive good headers. The search state collects ACQ_WIN headers. At the end of that window it declares alignment if at least ACQ_NEED of them were well formed. Otherwise it slips and starts a new window.

Once aligned, the block counts malformed headers inside repeating windows of LOSS_WIN headers. Reaching LOSS_NEED malformed headers inside one window drops alignment. At that moment the block raises a one-cycle notice, so that a downstream burst correlator can be switched back on. The defaults (64 of 64 to acquire, 16 of 64 to lose) give the conventional behaviour. Lowering ACQ_NEED gives tolerance to a noisy line while acquiring.

Top module: `block_lock_fsm`

## Requirements
- R1: After reset, the offset is 0, and the lock flag, slip and lost_hard are all 0.
- R2: A header of 2'b01 or 2'b10 counts as well formed. A header of 2'b00 or 2'b11 counts as malformed.
- R3: While unlocked, the lock flag rises in the cycle after the ACQ_WIN-th header of a window, if that window held at least ACQ_NEED well-formed headers.
- R4: A search window that ends with fewer than ACQ_NEED well-formed headers produces a one-cycle slip pulse in the cycle after its last header. In that same cycle the offset advances by one, and a new window starts.
- R5: The offset stays below BLOCK_BITS. An advance from BLOCK_BITS-1 wraps it to 0.
- R6: While locked, the LOSS_NEED-th malformed header within one window clears the lock flag in the next cycle, and lost_hard pulses for exactly that cycle.
- R7: While locked, the malformed count is cleared after every LOSS_WIN headers. So LOSS_NEED-1 malformed headers in each window never drop lock.
- R8: A cycle with hdr_vld low changes no output and no count.
- R9: Slip is never asserted while locked, and the offset does not move while lock is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_vld | input | 1 | A candidate block header is present |
| hdr | input | 2 | Framing bits of the candidate block |
| offset | output | $clog2(BLOCK_BITS) | Bit offset currently applied |
| locked | output | 1 | Block alignment held |
| slip | output | 1 | One-cycle request to shift alignment by one bit |
| lost_hard | output | 1 | One-cycle pulse when alignment is dropped |

## Verification
The embedded assertions check the per-cycle rules on every clock:
- the offset stays in range and a slip advances it by exactly one with wrap-around;
- slip and a held lock exclude each other;
- lost_hard appears only as lock falls;
- idle strobe cycles leave all outputs frozen.

The counting rules can only be shown by the bench's scenarios, driven against a behavioural model:
- a full sweep of all offsets on a malformed stream;
- acquisition that tolerates errors just under the threshold, and a failure one error past it;
- a locked stream that sits one error below the loss threshold for several windows;
- a stream that reaches the loss threshold.

// File: rtl/block_lock_fsm.sv
module block_lock_fsm #(
  parameter int BLOCK_BITS = 66,
  parameter int ACQ_NEED   = 64,
  parameter int ACQ_WIN    = 64,
  parameter int LOSS_NEED  = 16,
  parameter int LOSS_WIN   = 64,
  localparam int OW = $clog2(BLOCK_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdr_vld,
  input  logic [1:0]    hdr,
  output logic [OW-1:0] offset,
  output logic          locked,
  output logic          slip,
  output logic          lost_hard
);
  localparam int WMAX = (ACQ_WIN > LOSS_WIN) ? ACQ_WIN : LOSS_WIN;
  localparam int CW   = $clog2(WMAX + 1);

  logic [CW-1:0] seen, tally;

  wire           good     = hdr[1] ^ hdr[0];
  wire [CW-1:0]  seen_n   = seen + 1'b1;
  wire [CW-1:0]  tally_n  = tally + CW'(locked ? !good : good);
  wire           acq_end  = !locked && (seen_n == CW'(ACQ_WIN));
  wire           acq_ok   = tally_n >= CW'(ACQ_NEED);
  wire           loss_hit = locked && (tally_n >= CW'(LOSS_NEED));
  wire           loss_end = locked && (seen_n == CW'(LOSS_WIN));
  wire [OW-1:0]  off_inc  = (offset == OW'(BLOCK_BITS - 1)) ? '0 : offset + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset    <= '0;
      locked    <= 1'b0;
      slip      <= 1'b0;
      lost_hard <= 1'b0;
      seen      <= '0;
      tally     <= '0;
    end else begin
      slip      <= 1'b0;
      lost_hard <= 1'b0;
      if (hdr_vld) begin
        if (acq_end) begin
          seen  <= '0;
          tally <= '0;
          if (acq_ok) locked <= 1'b1;
          else begin
            slip   <= 1'b1;
            offset <= off_inc;
          end
        end else if (loss_hit) begin
          locked    <= 1'b0;
          lost_hard <= 1'b1;
          seen      <= '0;
          tally     <= '0;
        end else if (loss_end) begin
          seen  <= '0;
          tally <= '0;
        end else begin
          seen  <= seen_n;
          tally <= tally_n;
        end
      end
    end
  end

  p_offset_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    offset < OW'(BLOCK_BITS));

  p_slip_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slip |-> (offset == (($past(offset) == OW'(BLOCK_BITS - 1)) ? '0 : $past(offset) + 1'b1)));

  p_slip_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slip |-> !locked);

  p_hold_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(offset));

  p_lost_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lost_hard |-> (!locked && $past(locked)));

  p_idle_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_vld |=> ($stable(offset) && $stable(locked) && !slip && !lost_hard));

endmodule

// File: tb/sim_block_lock_fsm.sv
`timescale 1ns/1ps
module sim_block_lock_fsm;
  localparam int BB = 66, X = 60, Y = 64, W = 16, Z = 64;

  logic clk = 1'b0, rst_n = 1'b0, hdr_vld = 1'b0;
  logic [1:0] hdr = 2'b00;
  logic [6:0] offset;
  logic locked, slip, lost_hard;

  int checks = 0, errors = 0;
  int e_off = 0, e_lock = 0, e_slip = 0, e_lost = 0, m_seen = 0, m_tally = 0;
  int n_slips = 0;

  always #4 clk = ~clk;

  block_lock_fsm #(.BLOCK_BITS(BB), .ACQ_NEED(X), .ACQ_WIN(Y),
                   .LOSS_NEED(W), .LOSS_WIN(Z)) u0 (
    .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr(hdr),
    .offset(offset), .locked(locked), .slip(slip), .lost_hard(lost_hard));

  task automatic check(input string tag, input bit ok, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic step(input bit vld, input logic [1:0] h, input string tag);
    bit good;
    hdr_vld = vld; hdr = h;
    good = h[1] ^ h[0];
    e_slip = 0; e_lost = 0;
    if (vld) begin
      m_seen++;
      if (!e_lock) begin
        if (good) m_tally++;
        if (m_seen == Y) begin
          if (m_tally >= X) e_lock = 1;
          else begin e_slip = 1; e_off = (e_off + 1) % BB; end
          m_seen = 0; m_tally = 0;
        end
      end else begin
        if (!good) m_tally++;
        if (m_tally >= W) begin
          e_lock = 0; e_lost = 1; m_seen = 0; m_tally = 0;
        end else if (m_seen == Z) begin
          m_seen = 0; m_tally = 0;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (slip) n_slips++;
    check(tag, offset == 7'(e_off) && locked == e_lock[0] && slip == e_slip[0] && lost_hard == e_lost[0],
          $sformatf("off=%0d lock=%0b slip=%0b lost=%0b", offset, locked, slip, lost_hard),
          $sformatf("off=%0d lock=%0d slip=%0d lost=%0d", e_off, e_lock, e_slip, e_lost));
  endtask

  // n headers, the first nbad malformed (00/11 alternating), rest well formed (01/10)
  task automatic feed(input int n, input int nbad, input bit gaps, input string tag);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7 == 3)) step(1'b0, 2'b11, {tag, "/R8"});
      if (i < nbad) step(1'b1, (i % 2) ? 2'b11 : 2'b00, tag);
      else          step(1'b1, (i % 2) ? 2'b10 : 2'b01, tag);
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", offset == 0 && !locked && !slip && !lost_hard,
          $sformatf("off=%0d lock=%0b slip=%0b lost=%0b", offset, locked, slip, lost_hard), "all zero");
    rst_n = 1'b1;
    // R4/R5: fully malformed stream sweeps every offset and wraps
    feed(BB * Y, BB * Y, 1'b0, "R5");
    check("R5", offset == 0 && n_slips == BB, $sformatf("off=%0d slips=%0d", offset, n_slips),
          $sformatf("off=0 slips=%0d", BB));
    // R4: one error past the acquisition threshold, with idle gaps (R8)
    feed(Y, Y - X + 1, 1'b1, "R4");
    check("R4", offset == 1 && !locked, $sformatf("off=%0d lock=%0b", offset, locked), "off=1 lock=0");
    // R2/R3: exactly the tolerated number of malformed headers
    feed(Y, Y - X, 1'b1, "R3");
    check("R3", locked == 1'b1, $sformatf("%0b", locked), "1");
    // R7: one below the loss threshold in each of three windows
    feed(Z, W - 1, 1'b0, "R7");
    feed(Z, W - 1, 1'b1, "R7");
    feed(Z, W - 1, 1'b0, "R7");
    check("R7", locked == 1'b1 && offset == 1, $sformatf("lock=%0b off=%0d", locked, offset), "lock=1 off=1");
    // R6: reach the loss threshold
    feed(W, W, 1'b0, "R6");
    check("R6", !locked, $sformatf("%0b", locked), "0");
    // R9: back in search, a failing window slips again from the held offset
    feed(Y, Y, 1'b1, "R9");
    check("R9", offset == 2 && !locked, $sformatf("off=%0d lock=%0b", offset, locked), "off=2 lock=0");
    // R2: only 01/10 count; a clean window locks
    feed(Y, 0, 1'b0, "R2");
    check("R2", locked == 1'b1, $sformatf("%0b", locked), "1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule